// File: doc/BRIEF.md
# Vector Multi-Structure Load/Store Cracker

This block turns one vector multiple-structure load or store into a short, ordered run of micro-ops. It takes a command made of a register count, an elements-per-structure count, an element size code, a first vector register, a register increment, an alignment code, a base register and an offset register. It then emits one micro-op per cycle. A run holds memory transfers of 8 or 16 bytes, the interleave or deinterleave shuffles that move structured data between the vector registers and a scratch area, and an optional base-register update.

A decode stage pulses `start` with the command fields valid while `busy` is low. The command is captured at that edge. The micro-ops appear on the `uop_*` outputs on consecutive cycles, starting one cycle later. The block does not move data and does not access memory. It only describes the work for the execution stages. Any command that cannot be legally expanded becomes a single undefined-instruction micro-op.

Top module: `vmx_cracker`

## Requirements
- R1: A command is legal only when the register count is 1 to 4, the element count is 1 to 4, and the register count is a whole multiple of the element count. Any other command emits exactly one micro-op of kind 7 (undefined), with `uop_last`=1 and `uop_delay`=0.
- R2: Memory chunking depends on the register count:
  - 4 registers give two 16-byte transfers, at offsets 0 and 16.
  - 3 registers give a 16-byte transfer at offset 0 and an 8-byte transfer at offset 16.
  - 2 registers give one 16-byte transfer.
  - 1 register gives one 8-byte transfer.
  - `uop_wide`=1 means 16 bytes. `uop_imm` holds the offset and `uop_base` holds the base register.
- R3: Only the first memory micro-op has `uop_align_chk`=1 and carries the requested alignment code. A second memory micro-op has `uop_align_chk`=0 and alignment 0.
- R4: Offset register 15 means no base update. Offset register 13 gives a kind-5 micro-op that adds register count × 8 to the base (`uop_imm`). Any other offset register gives a kind-6 micro-op that adds that register (`uop_sreg`) to the base.
- R5: When the element count is above 1, memory micro-op k uses data register SCRATCH_BASE + 4k (default 64). Otherwise it uses 2·vd + 4k.
- R6: When the element count is above 1, there are (register count / element count) shuffle micro-ops, and `uop_imm` = 2·increment on each. Shuffle i pairs vector unit 2·vd + 2i with scratch unit SCRATCH_BASE + 4i:
  - A load deinterleave (kind 3) writes `uop_dreg` = vector and reads `uop_sreg` = scratch.
  - A store interleave (kind 4) writes `uop_dreg` = scratch and reads `uop_sreg` = vector.
  - Both carry the element count on `uop_elems`.
- R7: A load emits, in order, its memory micro-ops (kind 1), then the base update, then the deinterleaves. A store emits, in order, its interleaves, then its memory micro-ops (kind 2), then the base update.
- R8: A legal run has (count>2 ? 2 : 1) + (1 if base update) + (shuffle count) micro-ops. Every micro-op except the final one has `uop_delay`=1 and `uop_last`=0. The final one has `uop_last`=1 and `uop_delay`=0.
- R9: Timing and `busy`:
  - `start` is accepted only while `busy` is low, and `busy` is high on the cycle after acceptance.
  - Micro-ops appear on consecutive cycles, the first one in the cycle after that.
  - `busy` falls in the cycle that shows the final micro-op.
  - `start` while busy is ignored.
- R10: Reset clears `busy` and `uop_valid`. This includes a reset that arrives in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, taken when idle |
| is_store | input | 1 | 1 = store, 0 = load |
| regs | input | 3 | Register count |
| elems | input | 3 | Elements per structure |
| esize | input | 2 | Element size code, passed through |
| vd | input | 5 | First vector register |
| inc | input | 2 | Register increment |
| align | input | 2 | Alignment code |
| rn | input | 4 | Base register |
| rm | input | 4 | Offset register |
| busy | output | 1 | Run in progress |
| uop_valid | output | 1 | Micro-op present this cycle |
| uop_kind | output | 3 | 1 ld, 2 st, 3 deint, 4 inter, 5 base+imm, 6 base+reg, 7 undef |
| uop_dreg | output | 7 | Destination/data register unit |
| uop_sreg | output | 7 | Source register unit |
| uop_base | output | 4 | Base register |
| uop_imm | output | 8 | Offset or immediate |
| uop_wide | output | 1 | 16-byte transfer |
| uop_align | output | 2 | Alignment code applied |
| uop_align_chk | output | 1 | Alignment check enabled |
| uop_esize | output | 2 | Element size code |
| uop_elems | output | 3 | Element count for shuffles |
| uop_last | output | 1 | Final micro-op of run |
| uop_delay | output | 1 | Commit deferred to run end |

## Verification
The assertions take for granted only that `rst` is synchronous and that `start` means nothing while `busy` is high. They assume no legal field values, because every unsupported register count and element count folds into the undefined micro-op. The stimulus therefore sweeps every 3-bit register count against every 3-bit element count. This is done for loads and stores and for each of the three offset-register classes. The stimulus also presses `start` on purpose during a run and raises reset in the middle of one.

// File: rtl/vmx_pkg.sv
package vmx_pkg;
  localparam int VD_W   = 5;
  localparam int GPR_W  = 4;
  localparam int CNT_W  = 3;
  localparam int RIDX_W = 7;
  localparam int IMM_W  = 8;
  localparam int ESZ_W  = 2;
  localparam int AL_W   = 2;
  localparam int INC_W  = 2;
  localparam int STEP_W = 3;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_MEM_LD = 3'd1,
    K_MEM_ST = 3'd2,
    K_DEINT  = 3'd3,
    K_INTER  = 3'd4,
    K_WB_IMM = 3'd5,
    K_WB_REG = 3'd6,
    K_UNDEF  = 3'd7
  } uop_kind_e;

  typedef struct packed {
    logic              store;
    logic [CNT_W-1:0]  regs;
    logic [CNT_W-1:0]  elems;
    logic [ESZ_W-1:0]  esize;
    logic [VD_W-1:0]   vd;
    logic [INC_W-1:0]  inc;
    logic [AL_W-1:0]   align;
    logic [GPR_W-1:0]  rn;
    logic [GPR_W-1:0]  rm;
  } vmx_cmd_t;

  typedef struct packed {
    uop_kind_e         kind;
    logic [RIDX_W-1:0] dreg;
    logic [RIDX_W-1:0] sreg;
    logic [GPR_W-1:0]  base;
    logic [IMM_W-1:0]  imm;
    logic              wide;
    logic [AL_W-1:0]   align;
    logic              chk;
    logic [ESZ_W-1:0]  esize;
    logic [CNT_W-1:0]  elems;
    logic              last;
  } vmx_uop_t;
endpackage

// File: rtl/vmx_plan.sv
module vmx_plan import vmx_pkg::*; #(
  parameter int NO_WB_CODE = 15
) (
  input  logic [CNT_W-1:0]  regs,
  input  logic [CNT_W-1:0]  elems,
  input  logic [GPR_W-1:0]  rm,
  output logic              legal,
  output logic [1:0]        n_mem,
  output logic [1:0]        n_shuf,
  output logic              has_wb,
  output logic [STEP_W-1:0] total
);
  always_comb begin
    logic in_range;
    logic multiple;
    in_range = (regs >= 3'd1) && (regs <= 3'd4) && (elems >= 3'd1) && (elems <= 3'd4);
    case (elems)
      3'd1:    multiple = 1'b1;
      3'd2:    multiple = !regs[0];
      3'd3:    multiple = (regs == 3'd3);
      3'd4:    multiple = (regs == 3'd4);
      default: multiple = 1'b0;
    endcase
    legal = in_range && multiple;
    n_mem = (regs > 3'd2) ? 2'd2 : 2'd1;
    case (elems)
      3'd2:      n_shuf = regs[2:1];
      3'd3, 3'd4: n_shuf = 2'd1;
      default:   n_shuf = 2'd0;
    endcase
    has_wb = (rm != GPR_W'(NO_WB_CODE));
    total  = legal ? (STEP_W'(n_mem) + STEP_W'(has_wb) + STEP_W'(n_shuf)) : STEP_W'(1);
  end
endmodule

// File: rtl/vmx_uop_gen.sv
module vmx_uop_gen import vmx_pkg::*; #(
  parameter int SCRATCH_BASE = 64,
  parameter int IMM_WB_CODE  = 13
) (
  input  vmx_cmd_t          cmd,
  input  logic              legal,
  input  logic [1:0]        n_mem,
  input  logic [1:0]        n_shuf,
  input  logic              has_wb,
  input  logic [STEP_W-1:0] total,
  input  logic [STEP_W-1:0] step,
  output vmx_uop_t          uop
);
  localparam logic [RIDX_W-1:0] SCR = RIDX_W'(SCRATCH_BASE);
  typedef enum logic [1:0] {C_MEM, C_WB, C_SHUF} cls_e;

  always_comb begin
    cls_e              cls;
    logic [STEP_W-1:0] idx, nm, ns, nw;
    logic [RIDX_W-1:0] stage, vpair, scr;
    nm  = STEP_W'(n_mem);
    ns  = STEP_W'(n_shuf);
    nw  = STEP_W'(has_wb);
    cls = C_MEM;
    idx = '0;
    if (!cmd.store) begin
      if (step < nm)           begin cls = C_MEM;  idx = step; end
      else if (step < nm + nw) begin cls = C_WB; end
      else                     begin cls = C_SHUF; idx = step - nm - nw; end
    end else begin
      if (step < ns)           begin cls = C_SHUF; idx = step; end
      else if (step < ns + nm) begin cls = C_MEM;  idx = step - ns; end
      else                     begin cls = C_WB; end
    end
    stage = (cmd.elems > 3'd1) ? SCR : RIDX_W'({cmd.vd, 1'b0});
    vpair = RIDX_W'({cmd.vd, 1'b0}) + RIDX_W'({idx, 1'b0});
    scr   = SCR + RIDX_W'({idx, 2'b00});

    uop       = '0;
    uop.esize = cmd.esize;
    if (!legal) begin
      uop.kind = K_UNDEF;
    end else begin
      case (cls)
        C_MEM: begin
          uop.kind  = cmd.store ? K_MEM_ST : K_MEM_LD;
          uop.dreg  = stage + RIDX_W'({idx, 2'b00});
          uop.base  = cmd.rn;
          uop.imm   = (idx == '0) ? IMM_W'(0) : IMM_W'(16);
          uop.wide  = (idx == '0) ? (cmd.regs >= 3'd2) : (cmd.regs == 3'd4);
          uop.chk   = (idx == '0);
          uop.align = (idx == '0) ? cmd.align : '0;
        end
        C_SHUF: begin
          uop.kind  = cmd.store ? K_INTER : K_DEINT;
          uop.dreg  = cmd.store ? scr : vpair;
          uop.sreg  = cmd.store ? vpair : scr;
          uop.imm   = IMM_W'({cmd.inc, 1'b0});
          uop.elems = cmd.elems;
        end
        default: begin
          uop.base = cmd.rn;
          if (cmd.rm == GPR_W'(IMM_WB_CODE)) begin
            uop.kind = K_WB_IMM;
            uop.imm  = IMM_W'({cmd.regs, 3'b000});
          end else begin
            uop.kind = K_WB_REG;
            uop.sreg = RIDX_W'(cmd.rm);
          end
        end
      endcase
    end
    uop.last = (step == total - STEP_W'(1));
  end
endmodule

// File: rtl/vmx_cracker.sv
module vmx_cracker import vmx_pkg::*; #(
  parameter int SCRATCH_BASE = 64,
  parameter int NO_WB_CODE   = 15,
  parameter int IMM_WB_CODE  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_store,
  input  logic [CNT_W-1:0]  regs,
  input  logic [CNT_W-1:0]  elems,
  input  logic [ESZ_W-1:0]  esize,
  input  logic [VD_W-1:0]   vd,
  input  logic [INC_W-1:0]  inc,
  input  logic [AL_W-1:0]   align,
  input  logic [GPR_W-1:0]  rn,
  input  logic [GPR_W-1:0]  rm,
  output logic              busy,
  output logic              uop_valid,
  output logic [2:0]        uop_kind,
  output logic [RIDX_W-1:0] uop_dreg,
  output logic [RIDX_W-1:0] uop_sreg,
  output logic [GPR_W-1:0]  uop_base,
  output logic [IMM_W-1:0]  uop_imm,
  output logic              uop_wide,
  output logic [AL_W-1:0]   uop_align,
  output logic              uop_align_chk,
  output logic [ESZ_W-1:0]  uop_esize,
  output logic [CNT_W-1:0]  uop_elems,
  output logic              uop_last,
  output logic              uop_delay
);
  vmx_cmd_t          cmd_q;
  vmx_uop_t          nxt, out_q;
  logic [STEP_W-1:0] step_q, total;
  logic [1:0]        n_mem, n_shuf;
  logic              legal, has_wb;

  vmx_plan #(.NO_WB_CODE(NO_WB_CODE)) u_plan (
    .regs(cmd_q.regs), .elems(cmd_q.elems), .rm(cmd_q.rm),
    .legal(legal), .n_mem(n_mem), .n_shuf(n_shuf), .has_wb(has_wb), .total(total)
  );

  vmx_uop_gen #(.SCRATCH_BASE(SCRATCH_BASE), .IMM_WB_CODE(IMM_WB_CODE)) u_gen (
    .cmd(cmd_q), .legal(legal), .n_mem(n_mem), .n_shuf(n_shuf), .has_wb(has_wb),
    .total(total), .step(step_q), .uop(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      uop_valid <= 1'b0;
      step_q    <= '0;
      cmd_q     <= '0;
      out_q     <= '0;
    end else begin
      uop_valid <= 1'b0;
      if (!busy && start) begin
        cmd_q  <= '{store: is_store, regs: regs, elems: elems, esize: esize, vd: vd,
                    inc: inc, align: align, rn: rn, rm: rm};
        busy   <= 1'b1;
        step_q <= '0;
      end else if (busy) begin
        out_q     <= nxt;
        uop_valid <= 1'b1;
        step_q    <= step_q + STEP_W'(1);
        if (nxt.last) busy <= 1'b0;
      end
    end
  end

  assign uop_kind      = out_q.kind;
  assign uop_dreg      = out_q.dreg;
  assign uop_sreg      = out_q.sreg;
  assign uop_base      = out_q.base;
  assign uop_imm       = out_q.imm;
  assign uop_wide      = out_q.wide;
  assign uop_align     = out_q.align;
  assign uop_align_chk = out_q.chk;
  assign uop_esize     = out_q.esize;
  assign uop_elems     = out_q.elems;
  assign uop_last      = out_q.last;
  assign uop_delay     = !out_q.last;
endmodule

// File: rtl/vmx_cracker_chk.sv
module vmx_cracker_chk import vmx_pkg::*; (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             uop_valid,
  input logic [2:0]       uop_kind,
  input logic [IMM_W-1:0] uop_imm,
  input logic             uop_align_chk,
  input logic             uop_last,
  input logic             uop_delay
);
  logic is_mem;
  assign is_mem = (uop_kind == 3'd1) || (uop_kind == 3'd2);

  a_r9_stream_contig: assert property (@(posedge clk) disable iff (rst)
    uop_valid && !uop_last |=> uop_valid);
  a_r9_busy_in_run: assert property (@(posedge clk) disable iff (rst)
    uop_valid && !uop_last |-> busy);
  a_r9_busy_done: assert property (@(posedge clk) disable iff (rst)
    uop_valid && uop_last |-> !busy);
  a_r8_commit_flag: assert property (@(posedge clk) disable iff (rst)
    uop_valid |-> (uop_last != uop_delay));
  a_r1_undef_alone: assert property (@(posedge clk) disable iff (rst)
    uop_valid && (uop_kind == 3'd7) |-> uop_last && !$past(uop_valid));
  a_r2_offset_set: assert property (@(posedge clk) disable iff (rst)
    uop_valid && is_mem |-> (uop_imm == 8'd0) || (uop_imm == 8'd16));
  a_r3_second_unchecked: assert property (@(posedge clk) disable iff (rst)
    uop_valid && is_mem && (uop_imm == 8'd16) |-> !uop_align_chk);
endmodule

bind vmx_cracker vmx_cracker_chk u_chk (.*);

// File: tb/vmx_cracker_tb.sv
`timescale 1ns/1ps
module vmx_cracker_tb;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, is_store = 1'b0;
  logic [2:0] regs = '0, elems = '0;
  logic [1:0] esize = '0, inc = '0, align = '0;
  logic [4:0] vd = '0;
  logic [3:0] rn = '0, rm = '0;
  logic busy, uop_valid, uop_wide, uop_align_chk, uop_last, uop_delay;
  logic [2:0] uop_kind, uop_elems;
  logic [6:0] uop_dreg, uop_sreg;
  logic [3:0] uop_base;
  logic [7:0] uop_imm;
  logic [1:0] uop_align, uop_esize;

  always #4 clk = ~clk;

  vmx_cracker u_dut (.*);

  int n_chk = 0, n_bad = 0, n_exp = 0;
  int e_kind[8], e_dreg[8], e_sreg[8], e_base[8], e_imm[8], e_wide[8], e_align[8], e_chk[8], e_elems[8];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input int k, d, s, b, im, w, al, c, el);
    e_kind[n_exp] = k; e_dreg[n_exp] = d; e_sreg[n_exp] = s; e_base[n_exp] = b;
    e_imm[n_exp] = im; e_wide[n_exp] = w; e_align[n_exp] = al; e_chk[n_exp] = c;
    e_elems[n_exp] = el;
    n_exp++;
  endtask

  task automatic build_expected(input bit st, input int r, e, m, v, ic, al, b);
    int nm, ns, stg;
    bit ok;
    n_exp = 0;
    ok = (r >= 1) && (r <= 4) && (e >= 1) && (e <= 4);
    if (ok) ok = ((r % e) == 0);
    if (!ok) begin
      push(7, 0, 0, 0, 0, 0, 0, 0, 0);
      return;
    end
    nm  = (r > 2) ? 2 : 1;
    ns  = (e > 1) ? r / e : 0;
    stg = (e > 1) ? 64 : v * 2;
    if (st) for (int i = 0; i < ns; i++) push(4, 64 + 4 * i, v * 2 + 2 * i, 0, ic * 2, 0, 0, 0, e);
    for (int i = 0; i < nm; i++)
      push(st ? 2 : 1, stg + 4 * i, 0, b, 16 * i, (i == 0) ? (r >= 2) : (r == 4),
           (i == 0) ? al : 0, (i == 0), 0);
    if (m != 15) begin
      if (m == 13) push(5, 0, 0, b, r * 8, 0, 0, 0, 0);
      else         push(6, 0, m, b, 0, 0, 0, 0, 0);
    end
    if (!st) for (int i = 0; i < ns; i++) push(3, v * 2 + 2 * i, 64 + 4 * i, 0, ic * 2, 0, 0, 0, e);
  endtask

  task automatic issue(input bit st, input int r, e, m, v, ic, al, b, es);
    @(negedge clk);
    is_store = st; regs = 3'(r); elems = 3'(e); rm = 4'(m); vd = 5'(v);
    inc = 2'(ic); align = 2'(al); rn = 4'(b); esize = 2'(es); start = 1'b1;
    build_expected(st, r, e, m, v, ic, al, b);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9", "busy after accept", int'(busy), 1);
  endtask

  task automatic check_uop(input int j);
    bool_last: begin
      chk(uop_kind == 3'(e_kind[j]), (e_kind[j] == 7) ? "R1" : "R7", "kind", int'(uop_kind), e_kind[j]);
      chk(uop_last == (j == n_exp - 1), "R8", "last", int'(uop_last), int'(j == n_exp - 1));
      chk(uop_delay == (j != n_exp - 1), "R8", "delay", int'(uop_delay), int'(j != n_exp - 1));
    end
    case (e_kind[j])
      1, 2: begin
        chk(int'(uop_wide) == e_wide[j], "R2", "wide", int'(uop_wide), e_wide[j]);
        chk(int'(uop_imm) == e_imm[j], "R2", "offset", int'(uop_imm), e_imm[j]);
        chk(int'(uop_base) == e_base[j], "R2", "base", int'(uop_base), e_base[j]);
        chk(int'(uop_align_chk) == e_chk[j], "R3", "align check", int'(uop_align_chk), e_chk[j]);
        chk(int'(uop_align) == e_align[j], "R3", "align", int'(uop_align), e_align[j]);
        chk(int'(uop_dreg) == e_dreg[j], "R5", "data reg", int'(uop_dreg), e_dreg[j]);
      end
      3, 4: begin
        chk(int'(uop_dreg) == e_dreg[j], "R6", "shuffle dst", int'(uop_dreg), e_dreg[j]);
        chk(int'(uop_sreg) == e_sreg[j], "R6", "shuffle src", int'(uop_sreg), e_sreg[j]);
        chk(int'(uop_imm) == e_imm[j], "R6", "shuffle inc", int'(uop_imm), e_imm[j]);
        chk(int'(uop_elems) == e_elems[j], "R6", "shuffle elems", int'(uop_elems), e_elems[j]);
      end
      5: begin
        chk(int'(uop_imm) == e_imm[j], "R4", "wb imm", int'(uop_imm), e_imm[j]);
        chk(int'(uop_base) == e_base[j], "R4", "wb base", int'(uop_base), e_base[j]);
      end
      6: begin
        chk(int'(uop_sreg) == e_sreg[j], "R4", "wb reg", int'(uop_sreg), e_sreg[j]);
        chk(int'(uop_base) == e_base[j], "R4", "wb base", int'(uop_base), e_base[j]);
      end
      default: ;
    endcase
  endtask

  task automatic collect(input int hold);
    int got = 0;
    bit seen = 0, gap = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (c == 0) chk(uop_valid === 1'b1, "R9", "first uop one cycle after accept", int'(uop_valid), 1);
      if (uop_valid) begin
        if (gap) chk(1'b0, "R9", "gap inside run", c, 0);
        if (got < n_exp) check_uop(got);
        got++;
        seen = 1;
      end else if (seen) gap = 1;
      if (c + 1 == hold) start = 1'b0;
    end
    chk(got == n_exp, "R8", "micro-op count", got, n_exp);
    chk(busy === 1'b0, "R9", "busy after run", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(uop_valid === 1'b0, "R10", "valid in reset", int'(uop_valid), 0);
    chk(busy === 1'b0, "R10", "busy in reset", int'(busy), 0);
    rst = 1'b0;

    for (int st = 0; st < 2; st++)
      for (int r = 0; r < 8; r++)
        for (int e = 0; e < 8; e++)
          for (int ms = 0; ms < 3; ms++) begin
            issue(st[0], r, e, (ms == 0) ? 15 : (ms == 1) ? 13 : 2 + r,
                  (r * 7 + e * 3) % 32, 1 + (e & 1), (r + e) & 3, (r * 3 + e) % 16, e & 3);
            collect(0);
          end

    // R9: start held during a run is ignored
    issue(1'b0, 4, 2, 13, 9, 2, 3, 6, 1);
    is_store = 1'b1; regs = 3'd1; elems = 3'd1; rm = 4'd15; start = 1'b1;
    collect(2);

    // R10: reset in the middle of a run
    issue(1'b1, 4, 4, 7, 3, 1, 1, 2, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(uop_valid === 1'b0, "R10", "valid after mid-run reset", int'(uop_valid), 0);
    chk(busy === 1'b0, "R10", "busy after mid-run reset", int'(busy), 0);
    repeat (3) begin
      @(negedge clk);
      chk(uop_valid === 1'b0, "R10", "no output after mid-run reset", int'(uop_valid), 0);
    end
    issue(1'b0, 3, 1, 13, 5, 1, 2, 4, 2);
    collect(0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule